// File: doc/BRIEF.md
# Prioritized Control Register Bank

A storage register of parameterized width whose many control inputs are resolved in one fixed order of precedence. Three of the controls act at once, without a clock edge: a clear that drives every bit to 0, a preset that drives every bit to 1, and a load that makes the register show a separate async-data bus. The remaining controls take effect only at a rising clock edge: a clock enable, a synchronous clear, a synchronous load from its own bus, and the ordinary data input.

Precedence runs from the three immediate controls (clear above preset above async load) down through the clock enable, then synchronous clear, then synchronous load, with the data input lowest. The clock enable sits above the synchronous clear and load, so a deasserted enable freezes the register even when a synchronous clear or load is asserted. The block fits a datapath that needs a register whose control order can be predicted exactly and matches common storage-element conventions.

Top module: `prc_bank`

## Requirements
- R1: While async_clr is 1, q is all zeros at once, whatever every other input is doing.
- R2: While async_set is 1 and async_clr is 0, q is all ones at once.
- R3: While async_ld is 1 and both async_clr and async_set are 0, q equals async_val at once.
- R4: After every immediate control is released, q keeps the value it showed at the last rising clock edge that happened while that control was asserted, as long as async_val did not change between that edge and the release.
- R5: With no immediate control asserted and clk_en at 0 at a rising edge, q does not change, whatever sync_clr, sync_ld, ld_val and d are.
- R6: With clk_en at 1 and sync_clr at 1 at a rising edge, q becomes all zeros after that edge, even if sync_ld is 1. Between edges, sync_clr leaves q unchanged.
- R7: With clk_en at 1, sync_clr at 0 and sync_ld at 1 at a rising edge, q becomes ld_val.
- R8: With clk_en at 1 and both sync_clr and sync_ld at 0 at a rising edge, q becomes d.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| async_clr | input | 1 | Immediate clear to all zeros, active high, highest precedence |
| async_set | input | 1 | Immediate preset to all ones, active high |
| async_ld | input | 1 | Immediate load from async_val, active high |
| async_val | input | W | Data shown while async_ld governs the register |
| clk_en | input | 1 | Clock enable for every clocked control |
| sync_clr | input | 1 | Clocked clear, acts only when clk_en is 1 |
| sync_ld | input | 1 | Clocked load from ld_val |
| ld_val | input | W | Data for the clocked load |
| d | input | W | Ordinary data input |
| q | output | W | Register contents |

## Verification
A wrong precedence decision is visible on q either at once, for the immediate controls, or right after the next rising edge, for the clocked ones, so each of the 64 combinations of the six controls is applied and q is read twice: just after the inputs change and just after the following edge. A stored state that disagrees with what q showed during an immediate control only shows up after that control is released, so every combination ends with a release and a hold check before the next combination is applied. Data patterns change from one combination to the next, so a path that picks the wrong bus does not produce the expected value by chance.

// File: rtl/prc_pkg.sv
package prc_pkg;

  // Which control governs the register; the order is the precedence order.
  typedef enum logic [2:0] {
    SRC_ACLR  = 3'd0,
    SRC_ASET  = 3'd1,
    SRC_ALOAD = 3'd2,
    SRC_HOLD  = 3'd3,
    SRC_SCLR  = 3'd4,
    SRC_SLOAD = 3'd5,
    SRC_DATA  = 3'd6
  } src_e;

  function automatic src_e pick_src(
    input logic aclr, input logic aset, input logic ald,
    input logic en,   input logic sclr, input logic sld
  );
    if (aclr)       return SRC_ACLR;
    else if (aset)  return SRC_ASET;
    else if (ald)   return SRC_ALOAD;
    else if (!en)   return SRC_HOLD;
    else if (sclr)  return SRC_SCLR;
    else if (sld)   return SRC_SLOAD;
    else            return SRC_DATA;
  endfunction

  function automatic logic is_immediate(input src_e s);
    return (s == SRC_ACLR) || (s == SRC_ASET) || (s == SRC_ALOAD);
  endfunction

endpackage

// File: rtl/prc_arbiter.sv
module prc_arbiter
  import prc_pkg::*;
(
  input  logic aclr,
  input  logic aset,
  input  logic ald,
  input  logic en,
  input  logic sclr,
  input  logic sld,
  output src_e src,
  output logic imm_active,
  output logic capture
);
  always_comb begin
    src        = pick_src(aclr, aset, ald, en, sclr, sld);
    imm_active = is_immediate(src);
    capture    = (src == SRC_SCLR) || (src == SRC_SLOAD) || (src == SRC_DATA);
  end
endmodule

// File: rtl/prc_nextval.sv
module prc_nextval
  import prc_pkg::*;
#(
  parameter int W = 8
) (
  input  src_e         src,
  input  logic [W-1:0] imm_val,
  input  logic [W-1:0] ld_val,
  input  logic [W-1:0] d,
  input  logic [W-1:0] held,
  output logic [W-1:0] shown,
  output logic [W-1:0] nxt
);
  localparam logic [W-1:0] ZERO = '0;
  localparam logic [W-1:0] ONES = '1;

  always_comb begin
    unique case (src)
      SRC_ACLR:  shown = ZERO;
      SRC_ASET:  shown = ONES;
      SRC_ALOAD: shown = imm_val;
      default:   shown = held;
    endcase
    unique case (src)
      SRC_SCLR:  nxt = ZERO;
      SRC_SLOAD: nxt = ld_val;
      SRC_DATA:  nxt = d;
      default:   nxt = held;
    endcase
  end
endmodule

// File: rtl/prc_storage.sv
module prc_storage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         aclr,
  input  logic         aset,
  input  logic         ald,
  input  logic [W-1:0] aval,
  input  logic         capture,
  input  logic [W-1:0] nxt,
  output logic [W-1:0] held
);
  always_ff @(posedge clk or posedge aclr or posedge aset or posedge ald) begin
    if (aclr)         held <= '0;
    else if (aset)    held <= '1;
    else if (ald)     held <= aval;
    else if (capture) held <= nxt;
  end
endmodule

// File: rtl/prc_bank.sv
module prc_bank
  import prc_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         async_clr,
  input  logic         async_set,
  input  logic         async_ld,
  input  logic [W-1:0] async_val,
  input  logic         clk_en,
  input  logic         sync_clr,
  input  logic         sync_ld,
  input  logic [W-1:0] ld_val,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  src_e         win_src;
  logic         imm_active;
  logic         capture;
  logic [W-1:0] held;
  logic [W-1:0] nxt_val;
  logic [W-1:0] shown;

  prc_arbiter u_arb (
    .aclr(async_clr), .aset(async_set), .ald(async_ld),
    .en(clk_en), .sclr(sync_clr), .sld(sync_ld),
    .src(win_src), .imm_active(imm_active), .capture(capture)
  );

  prc_nextval #(.W(W)) u_nxt (
    .src(win_src), .imm_val(async_val), .ld_val(ld_val), .d(d),
    .held(held), .shown(shown), .nxt(nxt_val)
  );

  prc_storage #(.W(W)) u_st (
    .clk(clk), .aclr(async_clr), .aset(async_set), .ald(async_ld),
    .aval(async_val), .capture(capture), .nxt(nxt_val), .held(held)
  );

  assign q = shown;
endmodule

// File: rtl/prc_bank_chk.sv
module prc_bank_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         async_clr,
  input logic         async_set,
  input logic         async_ld,
  input logic [W-1:0] async_val,
  input logic         clk_en,
  input logic         sync_clr,
  input logic         sync_ld,
  input logic [W-1:0] ld_val,
  input logic [W-1:0] d,
  input logic [W-1:0] q,
  input logic         imm_active,
  input logic         capture
);
  wire any_imm = async_clr | async_set | async_ld;

  p_clear_zero_r1: assert property (@(posedge clk)
    async_clr |-> (q == '0));

  p_preset_ones_r2: assert property (@(posedge clk) disable iff (async_clr)
    async_set |-> (q == '1));

  p_aload_follow_r3: assert property (@(posedge clk) disable iff (async_clr || async_set)
    async_ld |-> (q == async_val));

  p_imm_flag_r3: assert property (@(posedge clk)
    imm_active == any_imm);

  p_enable_hold_r5: assert property (@(posedge clk) disable iff (any_imm)
    !clk_en |=> $stable(q));

  p_no_capture_r5: assert property (@(posedge clk) disable iff (any_imm)
    !clk_en |-> !capture);

  p_sclr_zero_r6: assert property (@(posedge clk) disable iff (any_imm)
    (clk_en && sync_clr) |=> (q == '0));

  p_sload_r7: assert property (@(posedge clk) disable iff (any_imm)
    (clk_en && !sync_clr && sync_ld) |=> (q == $past(ld_val)));

  p_data_r8: assert property (@(posedge clk) disable iff (any_imm)
    (clk_en && !sync_clr && !sync_ld) |=> (q == $past(d)));
endmodule

bind prc_bank prc_bank_chk #(.W(W)) u_chk (
  .clk(clk), .async_clr(async_clr), .async_set(async_set), .async_ld(async_ld),
  .async_val(async_val), .clk_en(clk_en), .sync_clr(sync_clr), .sync_ld(sync_ld),
  .ld_val(ld_val), .d(d), .q(q), .imm_active(imm_active), .capture(capture)
);

// File: tb/prc_bank_tb.sv
module prc_bank_tb;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         async_clr = 1'b1;
  logic         async_set = 1'b0;
  logic         async_ld  = 1'b0;
  logic [W-1:0] async_val = '0;
  logic         clk_en    = 1'b0;
  logic         sync_clr  = 1'b0;
  logic         sync_ld   = 1'b0;
  logic [W-1:0] ld_val    = '0;
  logic [W-1:0] d         = '0;
  logic [W-1:0] q;

  int n_cmp = 0;
  int n_bad = 0;
  logic done = 1'b0;
  logic [W-1:0] model;

  always #5 clk = ~clk;

  prc_bank #(.W(W)) u_dut (
    .clk(clk), .async_clr(async_clr), .async_set(async_set), .async_ld(async_ld),
    .async_val(async_val), .clk_en(clk_en), .sync_clr(sync_clr), .sync_ld(sync_ld),
    .ld_val(ld_val), .d(d), .q(q)
  );

  task automatic check(input string req, input logic [W-1:0] exp);
    n_cmp++;
    if (q !== exp) begin
      n_bad++;
      $display("FAIL %s: q=%02h expected %02h at %0t", req, q, exp, $time);
    end
  endtask

  function automatic string tag_now(input logic c, s, l, e, sc, sl);
    if (c) return "R1";
    if (s) return "R2";
    if (l) return "R3";
    if (!e) return "R5";
    if (sc) return "R6";
    if (sl) return "R7";
    return "R8";
  endfunction

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    #1 check("R1 reset", '0);
    @(negedge clk);
    async_clr = 1'b0;
    model = '0;
    #1 check("R4 hold after reset release", '0);

    for (int pass = 0; pass < 2; pass++) begin
      for (int i = 0; i < 64; i++) begin
        logic c, s, l, e, sc, sl;
        logic [W-1:0] av, lv, dv, imm_exp, edge_exp;
        string tg;
        {c, s, l, e, sc, sl} = 6'(i);
        av = W'(i * 37 + 5 + pass * 91);
        lv = W'(i * 13 + 170 + pass * 29);
        dv = W'(i * 59 + 66 + pass * 17);

        @(negedge clk);
        async_val = av; ld_val = lv; d = dv;
        clk_en = e; sync_clr = sc; sync_ld = sl;
        async_clr = c; async_set = s; async_ld = l;
        tg = tag_now(c, s, l, e, sc, sl);

        // Immediate view: only the async controls act between edges (R6 mid-cycle too).
        if (c)      imm_exp = '0;
        else if (s) imm_exp = '1;
        else if (l) imm_exp = av;
        else        imm_exp = model;
        #1 check({tg, " immediate"}, imm_exp);

        // After the next rising edge, full precedence applies.
        if (c || s || l)  edge_exp = imm_exp;
        else if (!e)      edge_exp = model;
        else if (sc)      edge_exp = '0;
        else if (sl)      edge_exp = lv;
        else              edge_exp = dv;
        @(posedge clk);
        #2 check({tg, " after edge"}, edge_exp);
        model = edge_exp;

        // Release everything with the enable low: the value must stay (R4, R5).
        @(negedge clk);
        async_clr = 1'b0; async_set = 1'b0; async_ld = 1'b0;
        clk_en = 1'b0; sync_clr = 1'b1; sync_ld = 1'b1;
        d = ~dv; ld_val = ~lv;
        #1 check("R4 hold after release", model);
        @(posedge clk);
        #2 check("R5 enable low holds", model);
        sync_clr = 1'b0; sync_ld = 1'b0;
      end
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule